// File: doc/BRIEF.md
# Host Frame Interval Timer

This block paces the frames of a full-speed/low-speed host port. It counts PHY clock cycles with a down-counter and raises a one-cycle frame-start strobe at each frame boundary. In full-speed operation the strobe is presented as a start-of-frame token request. In low-speed operation it is presented as a keep-alive request. An 11-bit frame number advances on every strobe. Token serialization and the PHY lie outside the block.

The frame length comes from one of two places. By default the block derives it from a 2-bit PHY clock select input, as one millisecond worth of PHY clocks. Software can instead write a 16-bit interval through a simple write port, but only while the port is enabled. A read port returns the stored interval register and the cycles left in the current frame.

Dropping the port enable, or pulsing soft reset, clears the frame counter, the frame number and the software override. A switch of the clock select to the 6 MHz setting waits for a soft reset before it is used.

Top module: `hst_frame_timer`

## Requirements
- R1: After reset, rd_interval reads 0xEA60 and rd_remain reads 0. frame_num reads 0, and no strobe is raised while port_en is low.
- R2: With no software override and clock select 2'b01 (48 MHz), successive strobes are 48000 cycles apart, in either speed mode.
- R3: Clock select 2'b10 (6 MHz) gives a 6000-cycle frame in low-speed mode. It is adopted only on a cycle with soft_rst high; until then the previous selection stays in use. Other select values are adopted on the next clock edge.
- R4: Clock select 2'b00, 2'b11, or 2'b10 with ls_mode=0 is reserved. While it is in effect no strobe is raised and rd_remain stays 0.
- R5: A write (wr_en high) while port_en is high and soft_rst is low stores wr_data into the interval register and turns on the software override. From then on, frames last wr_data cycles.
- R6: A write while port_en is low is ignored: rd_interval keeps its previous value.
- R7: frame_start is high for one cycle per frame. sof_req copies it when ls_mode=0, and keepalive_req copies it when ls_mode=1. The two are never high together.
- R8: frame_num increments by one on each strobe and wraps from 2047 to 0.
- R9: A cycle with port_en low or soft_rst high clears rd_remain, frame_num and the software override. After that the derived interval applies again, while the interval register keeps its value.
- R10: A stored interval of 0 behaves as 1: a strobe on every cycle.
- R11: The strobe appears in the first cycle the timer may run. After it, rd_remain shows interval-1 and counts down by one per cycle.
- R12: The reload at a strobe uses the interval in force before that edge. A write landing on the same edge changes only the following frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PHY clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enabled; gates writes and the timer |
| ls_mode | input | 1 | 1 = low-speed, 0 = full-speed |
| soft_rst | input | 1 | Soft reset pulse; clears timer state and adopts clock select |
| clk_sel | input | 2 | PHY clock select: 01 = 48 MHz, 10 = 6 MHz, others reserved |
| wr_en | input | 1 | Interval write strobe |
| wr_data | input | 16 | Interval value to write |
| rd_interval | output | 16 | Stored interval register |
| rd_remain | output | 16 | Cycles left in the current frame |
| frame_start | output | 1 | One-cycle frame boundary strobe |
| sof_req | output | 1 | Start-of-frame token request (full-speed) |
| keepalive_req | output | 1 | Keep-alive request (low-speed) |
| frame_num | output | 11 | Frame number |

## Verification
A software interval write and a frame-start reload can land on the same clock edge. The reload must then take the old interval, and the new value must shape only the frame after. The bench provokes this by issuing a write in the cycle where the strobe is visible. It then judges the result by rd_remain on the following cycle and by the lengths of the next two measured frames, which must equal the old and then the new interval. Randomized runs also mix writes with soft resets, enable drops and select changes, and compare every output against a cycle model in the bench.

// File: rtl/hst_ft_pkg.sv
package hst_ft_pkg;

   // PHY clock select codes; the encoding is decoded by the interval picker
   typedef enum logic [1:0] {
      CSEL_RSV_LO = 2'b00,
      CSEL_48M    = 2'b01,
      CSEL_6M     = 2'b10,
      CSEL_RSV_HI = 2'b11
   } csel_e;

   localparam int unsigned CSEL_W = 2;

endpackage

// File: rtl/hst_ft_csel_track.sv
module hst_ft_csel_track
   import hst_ft_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic [CSEL_W-1:0] clk_sel,
   output csel_e             sel_q
);

   csel_e sel_in;
   logic  adopt;

   assign sel_in = csel_e'(clk_sel);
   // the slow clock setting needs a soft reset; all others follow at once
   assign adopt  = soft_rst || (sel_in != CSEL_6M);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= CSEL_48M;
      end else if (adopt) begin
         sel_q <= sel_in;
      end
   end

   // R3: a request for the slow clock without soft reset leaves the selection alone
   a_r3_slow_needs_reset : assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == 2'b10 && !soft_rst) |=> (sel_q == $past(sel_q)));

endmodule

// File: rtl/hst_ft_intv_reg.sv
module hst_ft_intv_reg #(
   parameter int unsigned          IV_W     = 16,
   parameter logic [IV_W-1:0]      RESET_IV = 'hEA60
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            port_en,
   input  logic            soft_rst,
   input  logic            wr_en,
   input  logic [IV_W-1:0] wr_data,
   output logic [IV_W-1:0] intv_q,
   output logic            sw_set
);

   logic clr;
   logic wr_ok;

   assign clr   = !port_en || soft_rst;
   assign wr_ok = wr_en && !clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         intv_q <= RESET_IV;
      end else if (wr_ok) begin
         intv_q <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sw_set <= 1'b0;
      end else if (clr) begin
         sw_set <= 1'b0;
      end else if (wr_en) begin
         sw_set <= 1'b1;
      end
   end

   // R6: writes with the port disabled leave the register unchanged
   a_r6_wr_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !port_en) |=> (intv_q == $past(intv_q)));

   // R9: enable drop or soft reset removes the override
   a_r9_override_dropped : assert property (@(posedge clk) disable iff (!rst_n)
      (!port_en || soft_rst) |=> !sw_set);

   // R5: an accepted write lands in the register
   a_r5_wr_taken : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_en && !soft_rst) |=> (sw_set && intv_q == $past(wr_data)));

endmodule

// File: rtl/hst_ft_intv_pick.sv
module hst_ft_intv_pick
   import hst_ft_pkg::*;
#(
   parameter int unsigned IV_W       = 16,
   parameter int unsigned FAST_IV    = 48000,
   parameter int unsigned SLOW_IV    = 6000,
   parameter bit          CLAMP_ZERO = 1'b1
) (
   input  csel_e           sel_q,
   input  logic            ls_mode,
   input  logic            sw_set,
   input  logic [IV_W-1:0] intv_q,
   output logic            sel_ok,
   output logic [IV_W-1:0] reload
);

   localparam logic [IV_W-1:0] FAST_V = IV_W'(FAST_IV);
   localparam logic [IV_W-1:0] SLOW_V = IV_W'(SLOW_IV);
   localparam logic [IV_W-1:0] ONE_V  = IV_W'(1);

   if (FAST_IV == 0 || FAST_IV >= (64'd1 << IV_W)) begin : g_bad_fast
      $error("FAST_IV must be nonzero and fit in IV_W bits");
   end
   if (SLOW_IV == 0 || SLOW_IV >= (64'd1 << IV_W)) begin : g_bad_slow
      $error("SLOW_IV must be nonzero and fit in IV_W bits");
   end

   logic [IV_W-1:0] derived;
   logic [IV_W-1:0] active;

   always_comb begin
      derived = '0;
      sel_ok  = 1'b0;
      case (sel_q)
         CSEL_48M: begin
            derived = FAST_V;
            sel_ok  = 1'b1;
         end
         CSEL_6M: begin
            derived = SLOW_V;
            sel_ok  = ls_mode;
         end
         default: begin
            derived = '0;
            sel_ok  = 1'b0;
         end
      endcase
   end

   assign active = sw_set ? intv_q : derived;

   if (CLAMP_ZERO) begin : g_clamp
      // an interval of zero runs as an interval of one
      assign reload = (active == '0) ? '0 : (active - ONE_V);
   end else begin : g_raw
      assign reload = active - ONE_V;
   end

endmodule

// File: rtl/hst_ft_frame_ctr.sv
module hst_ft_frame_ctr #(
   parameter int unsigned IV_W = 16,
   parameter int unsigned FN_W = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            port_en,
   input  logic            soft_rst,
   input  logic            sel_ok,
   input  logic [IV_W-1:0] reload,
   output logic [IV_W-1:0] cnt_q,
   output logic [FN_W-1:0] fn_q,
   output logic            strobe
);

   localparam logic [IV_W-1:0] CNT_ONE = IV_W'(1);
   localparam logic [FN_W-1:0] FN_ONE  = FN_W'(1);

   if (FN_W < 1 || IV_W < 2) begin : g_bad_w
      $error("frame counter widths out of range");
   end

   logic run;
   logic clr;
   logic at_zero;

   assign clr     = !port_en || soft_rst;
   assign run     = port_en && sel_ok && !soft_rst;
   assign at_zero = (cnt_q == '0);
   assign strobe  = run && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (at_zero) begin
         cnt_q <= reload;
      end else begin
         cnt_q <= cnt_q - CNT_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fn_q <= '0;
      end else if (clr) begin
         fn_q <= '0;
      end else if (strobe) begin
         fn_q <= fn_q + FN_ONE;
      end
   end

   // R11: a running frame counts down by one
   a_r11_countdown : assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

   // R12: the reload takes the interval in force before the strobe edge
   a_r12_reload_old : assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> (cnt_q == $past(reload)));

   // R8: the frame number steps by one on each strobe, wrapping naturally
   a_r8_fn_step : assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> (fn_q == $past(fn_q) + FN_ONE));

   // R9: clearing conditions empty the count and frame number
   a_r9_clear : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0 && fn_q == '0));

endmodule

// File: rtl/hst_frame_timer.sv
module hst_frame_timer
   import hst_ft_pkg::*;
#(
   parameter int unsigned     IV_W       = 16,
   parameter int unsigned     FN_W       = 11,
   parameter logic [IV_W-1:0] RESET_IV   = 'hEA60,
   parameter int unsigned     FAST_IV    = 48000,
   parameter int unsigned     SLOW_IV    = 6000,
   parameter bit              CLAMP_ZERO = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            port_en,
   input  logic            ls_mode,
   input  logic            soft_rst,
   input  logic [1:0]      clk_sel,
   input  logic            wr_en,
   input  logic [IV_W-1:0] wr_data,
   output logic [IV_W-1:0] rd_interval,
   output logic [IV_W-1:0] rd_remain,
   output logic            frame_start,
   output logic            sof_req,
   output logic            keepalive_req,
   output logic [FN_W-1:0] frame_num
);

   csel_e           sel_q;
   logic [IV_W-1:0] intv_q;
   logic            sw_set;
   logic            sel_ok;
   logic [IV_W-1:0] reload;
   logic [IV_W-1:0] cnt_q;
   logic [FN_W-1:0] fn_q;
   logic            strobe;

   hst_ft_csel_track u_csel (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .clk_sel  (clk_sel),
      .sel_q    (sel_q)
   );

   hst_ft_intv_reg #(
      .IV_W     (IV_W),
      .RESET_IV (RESET_IV)
   ) u_ivreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .port_en  (port_en),
      .soft_rst (soft_rst),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .intv_q   (intv_q),
      .sw_set   (sw_set)
   );

   hst_ft_intv_pick #(
      .IV_W       (IV_W),
      .FAST_IV    (FAST_IV),
      .SLOW_IV    (SLOW_IV),
      .CLAMP_ZERO (CLAMP_ZERO)
   ) u_pick (
      .sel_q   (sel_q),
      .ls_mode (ls_mode),
      .sw_set  (sw_set),
      .intv_q  (intv_q),
      .sel_ok  (sel_ok),
      .reload  (reload)
   );

   hst_ft_frame_ctr #(
      .IV_W (IV_W),
      .FN_W (FN_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .port_en  (port_en),
      .soft_rst (soft_rst),
      .sel_ok   (sel_ok),
      .reload   (reload),
      .cnt_q    (cnt_q),
      .fn_q     (fn_q),
      .strobe   (strobe)
   );

   assign rd_interval   = intv_q;
   assign rd_remain     = cnt_q;
   assign frame_num     = fn_q;
   assign frame_start   = strobe;
   assign sof_req       = strobe && !ls_mode;
   assign keepalive_req = strobe && ls_mode;

   // R7: each strobe is exactly one kind of request
   a_r7_kind_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (sof_req != keepalive_req));

   // R4: a reserved select keeps the timer quiet
   a_r4_reserved_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok |-> (!frame_start && !sof_req && !keepalive_req));

   // R4: a reserved select holds the remaining count at zero
   a_r4_reserved_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ok |=> (rd_remain == '0));

endmodule

// File: tb/hst_frame_timer_tb_top.sv
module hst_frame_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_en = 1'b0;
   logic        ls_mode = 1'b0;
   logic        soft_rst = 1'b0;
   logic [1:0]  clk_sel = 2'b01;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_interval;
   logic [15:0] rd_remain;
   logic        frame_start;
   logic        sof_req;
   logic        keepalive_req;
   logic [10:0] frame_num;

   int n_chk = 0;
   int n_err = 0;
   int cyc_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   hst_frame_timer dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .port_en       (port_en),
      .ls_mode       (ls_mode),
      .soft_rst      (soft_rst),
      .clk_sel       (clk_sel),
      .wr_en         (wr_en),
      .wr_data       (wr_data),
      .rd_interval   (rd_interval),
      .rd_remain     (rd_remain),
      .frame_start   (frame_start),
      .sof_req       (sof_req),
      .keepalive_req (keepalive_req),
      .frame_num     (frame_num)
   );

   // reference model, built from the requirements
   logic [15:0] m_iv;
   logic        m_set;
   logic [1:0]  m_sel;
   logic [15:0] m_cnt;
   logic [10:0] m_fn;
   logic        t_run, t_clr;
   logic [15:0] t_act, t_rl;

   function automatic logic [15:0] f_der(logic [1:0] s);
      if (s == 2'b01) return 16'd48000;
      if (s == 2'b10) return 16'd6000;
      return 16'd0;
   endfunction

   function automatic bit f_ok(logic [1:0] s, logic ls);
      return (s == 2'b01) || (s == 2'b10 && ls);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_iv = 16'hEA60; m_set = 1'b0; m_sel = 2'b01; m_cnt = '0; m_fn = '0;
      end else begin
         t_run = port_en && f_ok(m_sel, ls_mode) && !soft_rst;
         t_clr = !port_en || soft_rst;
         t_act = m_set ? m_iv : f_der(m_sel);
         t_rl  = (t_act == 16'd0) ? 16'd0 : t_act - 16'd1;
         if (t_clr) begin
            m_cnt = '0; m_fn = '0;
         end else if (!t_run) begin
            m_cnt = '0;
         end else if (m_cnt == 16'd0) begin
            m_cnt = t_rl; m_fn = m_fn + 11'd1;
         end else begin
            m_cnt = m_cnt - 16'd1;
         end
         if (t_clr) m_set = 1'b0;
         else if (wr_en) begin m_set = 1'b1; m_iv = wr_data; end
         if (soft_rst || clk_sel != 2'b10) m_sel = clk_sel;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      logic e_stb;
      e_stb = port_en && f_ok(m_sel, ls_mode) && !soft_rst && (m_cnt == 16'd0);
      chk("R7 frame_start", 32'(frame_start), 32'(e_stb));
      chk("R7 sof_req", 32'(sof_req), 32'(e_stb && !ls_mode));
      chk("R7 keepalive_req", 32'(keepalive_req), 32'(e_stb && ls_mode));
      chk("R8 frame_num", 32'(frame_num), 32'(m_fn));
      chk("R11 rd_remain", 32'(rd_remain), 32'(m_cnt));
      chk("R5 rd_interval", 32'(rd_interval), 32'(m_iv));
   endtask

   task automatic cyc();
      @(negedge clk);
      compare_all();
   endtask

   task automatic settle();
      #1;
      compare_all();
   endtask

   task automatic wait_strobe(input int limit, output int n);
      n = 0;
      do begin
         cyc();
         n++;
      end while (!frame_start && n < limit);
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 150000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc_cnt);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int n;
      int strobes;
      bit saw_wrap;
      void'($urandom(32'd7321));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      cyc();
      // R1 reset state
      chk("R1 rd_interval", 32'(rd_interval), 32'hEA60);
      chk("R1 rd_remain", 32'(rd_remain), 0);
      chk("R1 frame_num", 32'(frame_num), 0);
      chk("R1 frame_start", 32'(frame_start), 0);

      // R11 first strobe at once; R12 write on the same edge uses derived interval
      port_en = 1'b1; wr_en = 1'b1; wr_data = 16'd100;
      settle();
      chk("R11 first strobe", 32'(frame_start), 1);
      chk("R7 sof_req fs", 32'(sof_req), 1);
      wait_strobe(60000, n);
      wr_en = 1'b0;
      chk("R2 derived period", 32'(n), 48000);
      chk("R5 rd_interval", 32'(rd_interval), 100);
      // R12 write landing on a strobe edge
      wr_en = 1'b1; wr_data = 16'd50;
      cyc();
      wr_en = 1'b0;
      chk("R12 remain after collision", 32'(rd_remain), 99);
      wait_strobe(1000, n);
      chk("R12 old interval frame", 32'(n), 99);
      wait_strobe(1000, n);
      chk("R5 R12 new interval frame", 32'(n), 50);

      // R6 write while disabled, R9 clear
      port_en = 1'b0; wr_en = 1'b1; wr_data = 16'h1234;
      cyc();
      wr_en = 1'b0;
      cyc();
      chk("R6 rd_interval kept", 32'(rd_interval), 50);
      chk("R9 frame_num cleared", 32'(frame_num), 0);
      chk("R9 rd_remain cleared", 32'(rd_remain), 0);
      chk("R1 no strobe disabled", 32'(frame_start), 0);

      // R3 slow select held until soft reset
      ls_mode = 1'b1; clk_sel = 2'b10;
      cyc();
      port_en = 1'b1;
      settle();
      chk("R7 keepalive_req ls", 32'(keepalive_req), 1);
      chk("R7 sof_req ls", 32'(sof_req), 0);
      cyc();
      chk("R3 R9 derived 48M still used", 32'(rd_remain), 47999);
      soft_rst = 1'b1;
      cyc();
      soft_rst = 1'b0;
      settle();
      chk("R3 strobe after soft reset", 32'(frame_start), 1);
      wait_strobe(10000, n);
      chk("R3 slow period", 32'(n), 6000);

      // R4 reserved selections
      ls_mode = 1'b0;
      strobes = 0;
      for (int i = 0; i < 200; i++) begin
         cyc();
         if (frame_start) strobes++;
      end
      chk("R4 6M in full-speed quiet", 32'(strobes), 0);
      chk("R4 remain zero", 32'(rd_remain), 0);
      clk_sel = 2'b00;
      strobes = 0;
      for (int i = 0; i < 100; i++) begin
         cyc();
         if (frame_start) strobes++;
      end
      chk("R4 select 00 quiet", 32'(strobes), 0);
      clk_sel = 2'b11;
      strobes = 0;
      for (int i = 0; i < 100; i++) begin
         cyc();
         if (frame_start) strobes++;
      end
      chk("R4 select 11 quiet", 32'(strobes), 0);

      // R10 zero interval, R8 wrap (slow frames to keep the run short)
      ls_mode = 1'b1; clk_sel = 2'b10; soft_rst = 1'b1;
      cyc();
      soft_rst = 1'b0;
      cyc();
      wr_en = 1'b1; wr_data = 16'd0;
      cyc();
      wr_en = 1'b0;
      wait_strobe(10000, n);
      for (int i = 0; i < 4; i++) begin
         wait_strobe(5, n);
         chk("R10 zero interval every cycle", 32'(n), 1);
      end
      saw_wrap = 1'b0;
      for (int i = 0; i < 2100; i++) begin
         logic [10:0] prev;
         prev = frame_num;
         cyc();
         if (prev == 11'd2047 && frame_num == 11'd0) saw_wrap = 1'b1;
      end
      chk("R8 frame number wrap", 32'(saw_wrap), 1);

      // randomized mix checked against the model
      for (int i = 0; i < 4000; i++) begin
         cyc();
         wr_en    = ($urandom % 8) == 0;
         wr_data  = 16'($urandom % 40);
         soft_rst = ($urandom % 64) == 0;
         if (($urandom % 50) == 0) port_en = ~port_en;
         if (($urandom % 100) == 0) clk_sel = 2'($urandom % 4);
         if (($urandom % 100) == 0) ls_mode = ~ls_mode;
      end
      cyc();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule